// File: doc/BRIEF.md
# Hot-Page Filtered Access Recorder

This block sits beside a processor's first-level address translation and sees only its translation misses. Each miss arrives as a virtual page number tagged with an address-space identifier. A large set-associative buffer holds recently missed pages and drops repeat misses to them. A small fully-associative filter with least-recently-used order catches pages that the buffer has just lost to set conflicts. A miss that gets past both stages is appended to an on-chip log in arrival order. The log holds no physical addresses and feeds nothing back into translation.

When the log fills, the block raises an exception line. Software reads the log by index through a read window, then pulses a clear that rewinds the write pointer and drops the exception. Misses that qualify while the log is full are lost and counted in a sticky counter. Software can switch the whole block off, and it can probe either stage for any page.

The event input is a valid/ready stream. Ready is held high at all times, so the producer is never stalled and one event is taken on every cycle that valid is high. No other back-pressure exists.

Top module: `pat_top`

## Requirements
- R1: `miss_ready` is 1 in every cycle after reset, and every event with `miss_valid` high is accepted in that cycle.
- R2: An accepted event whose page is present in the buffer is a buffer hit. It leaves the log, the pointer and the overflow count unchanged.
- R3: The page identity is the pair {ASID, VPN}. The same VPN under two different ASIDs is two different pages.
- R4: The buffer has PAB_ENTRIES/PAB_WAYS sets, selected by the low VPN bits. On a miss the page replaces the least recently used way of its set, and the evicted page is discarded. A hit makes that way the most recently used.
- R5: The filter is looked up and updated, with LRU order over FILT_ENTRIES entries, on every buffer miss and only then. A buffer miss that hits in the filter is not logged.
- R6: A miss in both stages is written at index `log_wr_ptr`, and the pointer then advances by one. `log_rd_data` for index i shows the word {ASID, VPN}, with the ASID in the upper bits.
- R7: `log_exc` rises in the cycle after the write that makes `log_wr_ptr` equal LOG_DEPTH. It stays high until a clear.
- R8: While the log is full and no clear is applied, a qualifying event is dropped. `ovf_count` then rises by one and saturates at its maximum. The counter is cleared only by reset.
- R9: A `log_clear` pulse sets the pointer to 0 and drops `log_exc` on the next edge. A qualifying event in the same cycle is written at index 0, which leaves the pointer at 1.
- R10: While `enable` is 0, events change no state: buffer, filter, log, pointer and overflow count all stay as they were.
- R11: `probe_buf_hit` and `probe_filt_hit` show, with no clock delay, whether the probed {ASID, VPN} is present in the buffer and in the filter.
- R12: After reset the pointer, exception and overflow count are 0, and both stages are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable from software |
| miss_valid | input | 1 | Translation-miss event valid |
| miss_ready | output | 1 | Always 1; the event is taken |
| miss_asid | input | ASID_W | Address-space identifier of the event |
| miss_vpn | input | VPN_W | Virtual page number of the event |
| log_clear | input | 1 | Pulse: rewind write pointer, drop exception |
| log_rd_idx | input | log2(LOG_DEPTH) | Log read index |
| log_rd_data | output | ASID_W+VPN_W | Log word at the read index |
| log_wr_ptr | output | log2(LOG_DEPTH+1) | Number of valid log entries |
| log_exc | output | 1 | Log-full exception |
| ovf_count | output | OVF_W | Sticky count of dropped events |
| probe_asid | input | ASID_W | Probe ASID |
| probe_vpn | input | VPN_W | Probe VPN |
| probe_buf_hit | output | 1 | Probed page is in the buffer |
| probe_filt_hit | output | 1 | Probed page is in the filter |

## Verification
A corrupted buffer or filter shows in the log within a few events. A page that should be filtered is logged, or a hot page is logged again, and the pointer moves one cycle after the event. The probe outputs show such a fault in the same cycle. A pointer or exception fault shows on `log_wr_ptr`, `log_exc` and `ovf_count` one edge after the event or clear that caused it. The bench runs a queue-based model of both LRU stages and the log, and it compares the pointer, exception, count and every valid log word on every clock.

// File: rtl/pat_pkg.sv
package pat_pkg;
  // Where an accepted event ended up in the two-stage filter.
  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_BUF  = 2'd1,
    CLS_FILT = 2'd2,
    CLS_NEW  = 2'd3
  } acc_cls_e;
endpackage

// File: rtl/pat_pab.sv
// Set-associative hot-page buffer, per-set LRU by rank counters.
module pat_pab #(
  parameter int ENTRIES = 2048,
  parameter int WAYS    = 4,
  parameter int KEY_W   = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] look_key,
  input  logic             upd,
  output logic             hit,
  input  logic [KEY_W-1:0] probe_key,
  output logic             probe_hit
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [KEY_W-1:0] key_q  [SETS][WAYS];
  logic             vld_q  [SETS][WAYS];
  logic [WAY_W-1:0] rank_q [SETS][WAYS];

  logic [SET_W-1:0] lset, pset;
  logic [WAY_W-1:0] hit_way, vic_way, sel_way, sel_rank;

  assign lset = look_key[SET_W-1:0];
  assign pset = probe_key[SET_W-1:0];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lset][w] && key_q[lset][w] == look_key) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (rank_q[lset][w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
    end
    sel_way  = hit ? hit_way : vic_way;
    sel_rank = rank_q[lset][sel_way];
  end

  always_comb begin
    probe_hit = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[pset][w] && key_q[pset][w] == probe_key) probe_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          rank_q[s][w] <= WAY_W'(w);
        end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way) begin
          vld_q[lset][w]  <= 1'b1;
          rank_q[lset][w] <= '0;
        end else if (rank_q[lset][w] < sel_rank) begin
          rank_q[lset][w] <= rank_q[lset][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd && !hit) key_q[lset][sel_way] <= look_key;
  end
endmodule

// File: rtl/pat_filt.sv
// Fully-associative victim filter kept in MRU-first order.
module pat_filt #(
  parameter int ENTRIES = 64,
  parameter int KEY_W   = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] look_key,
  input  logic             upd,
  output logic             hit,
  input  logic [KEY_W-1:0] probe_key,
  output logic             probe_hit
);
  localparam int POS_W = $clog2(ENTRIES);

  logic [KEY_W-1:0] ent_q [ENTRIES];
  logic             vld_q [ENTRIES];
  logic [POS_W-1:0] hit_pos, cut_pos;

  always_comb begin
    hit       = 1'b0;
    hit_pos   = '0;
    probe_hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && ent_q[i] == look_key) begin
        hit     = 1'b1;
        hit_pos = POS_W'(i);
      end
      if (vld_q[i] && ent_q[i] == probe_key) probe_hit = 1'b1;
    end
    cut_pos = hit ? hit_pos : POS_W'(ENTRIES - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
    end else if (upd) begin
      vld_q[0] <= 1'b1;
      for (int i = 1; i < ENTRIES; i++)
        if (POS_W'(i) <= cut_pos) vld_q[i] <= vld_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      ent_q[0] <= look_key;
      for (int i = 1; i < ENTRIES; i++)
        if (POS_W'(i) <= cut_pos) ent_q[i] <= ent_q[i-1];
    end
  end
endmodule

// File: rtl/pat_log.sv
// Append-only access log with full exception and sticky drop counter.
module pat_log #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 44,
  parameter int OVF_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       append,
  input  logic [WORD_W-1:0]          word,
  input  logic                       clear,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [WORD_W-1:0]          rd_data,
  output logic [$clog2(DEPTH+1)-1:0] wr_ptr,
  output logic                       exc,
  output logic [OVF_W-1:0]           ovf
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q, base, ptr_n;
  logic              exc_q;
  logic [OVF_W-1:0]  ovf_q;
  logic              room, do_wr, do_drop;

  assign base    = clear ? '0 : ptr_q;
  assign room    = base != PTR_W'(DEPTH);
  assign do_wr   = append && room;
  assign do_drop = append && !room;
  assign ptr_n   = base + PTR_W'(do_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      exc_q <= 1'b0;
      ovf_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      exc_q <= ptr_n == PTR_W'(DEPTH);
      if (do_drop && ovf_q != {OVF_W{1'b1}}) ovf_q <= ovf_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[base[IDX_W-1:0]] <= word;
  end

  assign rd_data = mem_q[rd_idx];
  assign wr_ptr  = ptr_q;
  assign exc     = exc_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/pat_top.sv
module pat_top
  import pat_pkg::*;
#(
  parameter int ASID_W       = 8,
  parameter int VPN_W        = 36,
  parameter int PAB_ENTRIES  = 2048,
  parameter int PAB_WAYS     = 4,
  parameter int FILT_ENTRIES = 64,
  parameter int LOG_DEPTH    = 128,
  parameter int OVF_W        = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enable,
  input  logic                           miss_valid,
  output logic                           miss_ready,
  input  logic [ASID_W-1:0]              miss_asid,
  input  logic [VPN_W-1:0]               miss_vpn,
  input  logic                           log_clear,
  input  logic [$clog2(LOG_DEPTH)-1:0]   log_rd_idx,
  output logic [ASID_W+VPN_W-1:0]        log_rd_data,
  output logic [$clog2(LOG_DEPTH+1)-1:0] log_wr_ptr,
  output logic                           log_exc,
  output logic [OVF_W-1:0]               ovf_count,
  input  logic [ASID_W-1:0]              probe_asid,
  input  logic [VPN_W-1:0]               probe_vpn,
  output logic                           probe_buf_hit,
  output logic                           probe_filt_hit
);
  localparam int KEY_W = ASID_W + VPN_W;

  logic [KEY_W-1:0] ev_key, pr_key;
  logic             acc, buf_hit, filt_hit;
  acc_cls_e         cls;

  assign miss_ready = 1'b1;
  assign acc    = miss_valid && enable;
  assign ev_key = {miss_asid, miss_vpn};
  assign pr_key = {probe_asid, probe_vpn};

  always_comb begin
    if (!acc)          cls = CLS_IDLE;
    else if (buf_hit)  cls = CLS_BUF;
    else if (filt_hit) cls = CLS_FILT;
    else               cls = CLS_NEW;
  end

  pat_pab #(.ENTRIES(PAB_ENTRIES), .WAYS(PAB_WAYS), .KEY_W(KEY_W)) u_pab (
    .clk(clk), .rst_n(rst_n), .look_key(ev_key), .upd(acc), .hit(buf_hit),
    .probe_key(pr_key), .probe_hit(probe_buf_hit)
  );

  pat_filt #(.ENTRIES(FILT_ENTRIES), .KEY_W(KEY_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .look_key(ev_key),
    .upd(cls == CLS_FILT || cls == CLS_NEW), .hit(filt_hit),
    .probe_key(pr_key), .probe_hit(probe_filt_hit)
  );

  pat_log #(.DEPTH(LOG_DEPTH), .WORD_W(KEY_W), .OVF_W(OVF_W)) u_log (
    .clk(clk), .rst_n(rst_n), .append(cls == CLS_NEW), .word(ev_key),
    .clear(log_clear), .rd_idx(log_rd_idx), .rd_data(log_rd_data),
    .wr_ptr(log_wr_ptr), .exc(log_exc), .ovf(ovf_count)
  );
endmodule

// File: rtl/pat_top_chk.sv
module pat_top_chk #(
  parameter int LOG_DEPTH = 128,
  parameter int OVF_W     = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           enable,
  input logic                           miss_valid,
  input logic                           miss_ready,
  input logic                           log_clear,
  input logic [$clog2(LOG_DEPTH+1)-1:0] log_wr_ptr,
  input logic                           log_exc,
  input logic [OVF_W-1:0]               ovf_count
);
  localparam int PTR_W = $clog2(LOG_DEPTH + 1);

  // R1
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> miss_ready);
  // R12
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr_ptr <= PTR_W'(LOG_DEPTH));
  // R7
  exc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_exc) |-> log_wr_ptr == PTR_W'(LOG_DEPTH));
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_exc && !log_clear) |=> $stable(log_wr_ptr));
  // R8
  ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_count >= $past(ovf_count));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_clear |=> (log_wr_ptr <= PTR_W'(1)) && (log_exc == (LOG_DEPTH == 1)));
  // R10
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !log_clear) |=> $stable(log_wr_ptr) && $stable(ovf_count));
endmodule

bind pat_top pat_top_chk #(.LOG_DEPTH(LOG_DEPTH), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .miss_valid(miss_valid),
  .miss_ready(miss_ready), .log_clear(log_clear), .log_wr_ptr(log_wr_ptr),
  .log_exc(log_exc), .ovf_count(ovf_count)
);

// File: tb/pat_top_test.sv
`timescale 1ns/1ps
module pat_top_test;
  localparam int AW = 4, VW = 12, ENT = 128, WAYS = 2, FE = 4, LD = 8, OW = 8;
  localparam int SETS = ENT / WAYS;
  typedef logic [AW+VW-1:0] key_t;

  logic clk = 0, rst_n = 0, enable = 0, miss_valid = 0, log_clear = 0;
  logic miss_ready, log_exc, probe_buf_hit, probe_filt_hit;
  logic [AW-1:0] miss_asid = '0, probe_asid = '0;
  logic [VW-1:0] miss_vpn = '0, probe_vpn = '0;
  logic [2:0] log_rd_idx = '0;
  logic [AW+VW-1:0] log_rd_data;
  logic [3:0] log_wr_ptr;
  logic [OW-1:0] ovf_count;

  always #4 clk = ~clk;

  pat_top #(.ASID_W(AW), .VPN_W(VW), .PAB_ENTRIES(ENT), .PAB_WAYS(WAYS),
            .FILT_ENTRIES(FE), .LOG_DEPTH(LD), .OVF_W(OW)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  key_t pab_m [SETS][$];
  key_t filt_m [$];
  key_t log_m [LD];
  int ptr_m = 0, ovf_m = 0;
  bit exc_m = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int qfind(input key_t q[$], input key_t k);
    for (int i = 0; i < q.size(); i++) if (q[i] == k) return i;
    return -1;
  endfunction

  task automatic model(input bit v, input bit en, input key_t k, input bit clr);
    bit acc, ph, fh, q;
    int s, ix, base;
    acc = v && en; ph = 0; fh = 0;
    if (acc) begin
      s = int'(k[5:0]);
      ix = qfind(pab_m[s], k);
      if (ix >= 0) begin ph = 1; pab_m[s].delete(ix); end
      pab_m[s].push_front(k);
      if (pab_m[s].size() > WAYS) void'(pab_m[s].pop_back());
      if (!ph) begin
        ix = qfind(filt_m, k);
        if (ix >= 0) begin fh = 1; filt_m.delete(ix); end
        filt_m.push_front(k);
        if (filt_m.size() > FE) void'(filt_m.pop_back());
      end
    end
    q = acc && !ph && !fh;
    base = clr ? 0 : ptr_m;
    if (q) begin
      if (base < LD) begin log_m[base] = k; base++; end
      else if (ovf_m < 255) ovf_m++;
    end
    ptr_m = base;
    exc_m = (ptr_m == LD);
  endtask

  task automatic compare();
    chk(miss_ready === 1'b1, "R1 ready", miss_ready, 1);
    chk(log_wr_ptr == 4'(ptr_m), "R6 wr_ptr", log_wr_ptr, ptr_m);
    chk(log_exc == exc_m, "R7 exception", log_exc, exc_m);
    chk(ovf_count == OW'(ovf_m), "R8 overflow count", ovf_count, ovf_m);
    for (int i = 0; i < ptr_m; i++) begin
      log_rd_idx = 3'(i); #0.1;
      chk(log_rd_data == log_m[i], "R6 log word", log_rd_data, log_m[i]);
    end
  endtask

  // one cycle; called at a falling edge
  task automatic step(input bit v, input logic [AW-1:0] a, input logic [VW-1:0] p, input bit clr);
    miss_valid = v; miss_asid = a; miss_vpn = p; log_clear = clr;
    @(posedge clk);
    model(v, enable, {a, p}, clr);
    @(negedge clk);
    miss_valid = 0; log_clear = 0;
    compare();
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [VW-1:0] p, input string tag);
    key_t k;
    k = {a, p};
    probe_asid = a; probe_vpn = p; #0.1;
    chk(probe_buf_hit == (qfind(pab_m[int'(k[5:0])], k) >= 0), {tag, " buffer probe"},
        probe_buf_hit, qfind(pab_m[int'(k[5:0])], k) >= 0);
    chk(probe_filt_hit == (qfind(filt_m, k) >= 0), {tag, " filter probe"},
        probe_filt_hit, qfind(filt_m, k) >= 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst_n = 1; enable = 1;
    @(negedge clk);
    // R12 reset state
    chk(log_wr_ptr == 0, "R12 pointer", log_wr_ptr, 0);
    chk(log_exc == 0, "R12 exception", log_exc, 0);
    chk(ovf_count == 0, "R12 overflow", ovf_count, 0);
    probe(1, 5, "R12");
    // first access logged, repeat is a buffer hit (R2)
    step(1, 1, 5, 0);
    chk(log_wr_ptr == 1, "R6 first append", log_wr_ptr, 1);
    step(1, 1, 5, 0);
    chk(log_wr_ptr == 1, "R2 hot page not logged", log_wr_ptr, 1);
    // R3 same VPN, other ASID
    step(1, 2, 5, 0);
    chk(log_wr_ptr == 2, "R3 distinct ASID logged", log_wr_ptr, 2);
    log_rd_idx = 1; #0.1;
    chk(log_rd_data == {4'd2, 12'd5}, "R6 word layout", log_rd_data, {4'd2, 12'd5});
    // R4 set conflict evicts LRU way (page 1:5)
    step(1, 1, 69, 0);
    probe(1, 5, "R4");
    chk(probe_buf_hit == 0, "R4 LRU way evicted", probe_buf_hit, 0);
    probe(2, 5, "R4");
    // R5 evicted page caught by filter
    step(1, 1, 5, 0);
    chk(log_wr_ptr == 3, "R5 filter hit not logged", log_wr_ptr, 3);
    probe(1, 5, "R5");
    probe(1, 69, "R11");
    // R10 disabled: no state change
    enable = 0;
    step(1, 3, 7, 0);
    step(1, 3, 7, 0);
    probe(3, 7, "R10");
    chk(probe_buf_hit == 0, "R10 buffer untouched", probe_buf_hit, 0);
    chk(log_wr_ptr == 3, "R10 log untouched", log_wr_ptr, 3);
    enable = 1;
    // fill log (R7) then drop (R8)
    for (int i = 0; i < 5; i++) step(1, 4, 12'(200 + i), 0);
    chk(log_exc == 1, "R7 exception at full", log_exc, 1);
    step(1, 4, 300, 0);
    step(1, 4, 301, 0);
    chk(ovf_count == 2, "R8 drops counted", ovf_count, 2);
    chk(log_wr_ptr == 8, "R8 pointer held", log_wr_ptr, 8);
    // R9 clear with simultaneous qualifying access
    step(1, 5, 400, 1);
    chk(log_wr_ptr == 1, "R9 clear plus append", log_wr_ptr, 1);
    chk(log_exc == 0, "R9 exception dropped", log_exc, 0);
    log_rd_idx = 0; #0.1;
    chk(log_rd_data == {4'd5, 12'd400}, "R9 entry zero", log_rd_data, {4'd5, 12'd400});
    step(0, 0, 0, 1);
    chk(log_wr_ptr == 0, "R9 plain clear", log_wr_ptr, 0);
    // mixed stream with reuse, conflicts, clears and enable toggles
    seed = 7;
    for (int n = 0; n < 600; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      enable = ((seed >> 20) % 16) != 0;
      step(((seed >> 4) % 8) != 0, 4'((seed >> 8) % 3), 12'(((seed >> 11) % 12) * 64 + (seed >> 16) % 3),
           ((seed >> 24) % 20) == 0);
      if (n % 50 == 0) probe(4'((seed >> 9) % 3), 12'((seed >> 13) % 3), "R11");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule